// File: doc/BRIEF.md
# Unsigned Integer and Fractional Divider

This block divides one 16-bit unsigned operand by another over several clock cycles. A single-cycle `start` strobe captures the dividend, the divisor and a mode select. In integer mode the unit returns the whole-number quotient and the remainder of dividend / divisor. In fractional mode the dividend is treated as the upper half of a 32-bit value, so the unit returns floor(dividend * 65536 / divisor) and the remainder. This gives a binary fraction when the divisor is larger than the dividend. Three status flags go with every result: zero quotient, fractional overflow and divide by zero.

The datapath is a restoring shift-subtract divider that resolves one quotient bit per clock. Both modes use the same datapath and differ only in how the partial remainder and the shift register are seeded. A zero divisor, and a fractional request that cannot fit in 16 bits, skip the iterations and complete on the accepting edge with a saturated quotient. A `done` strobe marks each completion. The results stay on the outputs until the next completion.

Top module: `udiv_unit`

## Requirements
- R1: Integer mode (`frac_mode`=0) with a nonzero divisor gives `quotient` = floor(dividend/divisor) and `remainder` = dividend mod divisor, so remainder < divisor.
- R2: Fractional mode (`frac_mode`=1) with divisor > dividend gives `quotient` = floor(dividend*65536/divisor) and `remainder` = (dividend*65536) mod divisor.
- R3: `flag_c` is 1 exactly when the captured divisor is zero, in both modes.
- R4: `flag_v` is 1 exactly when fractional mode is requested with divisor <= dividend. In integer mode `flag_v` is always 0.
- R5: `flag_z` is 1 exactly when the reported `quotient` is 0x0000.
- R6: A zero divisor, or a fractional overflow, reports `quotient` = 0xFFFF and `remainder` = dividend, with `done` high right after the clock edge that accepts `start`.
- R7: Any other request keeps `busy` high and raises `done` right after the 16th clock edge that follows the accepting edge. `busy` falls on that same edge.
- R8: `done` is high for one cycle per completion, and the results hold until the next completion. After reset `done`, `busy`, `quotient`, `remainder` and all flags are 0.
- R9: `start` is ignored while `busy` is high. The operands and mode presented then have no effect on the running result or its timing.
- R10: `start` is accepted in the cycle where `done` is high, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request strobe; captures operands and mode when idle |
| frac_mode | input | 1 | 0 = integer division, 1 = fractional division |
| dividend | input | 16 | Unsigned dividend |
| divisor | input | 16 | Unsigned divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion strobe |
| quotient | output | 16 | Quotient of the last completed operation |
| remainder | output | 16 | Remainder of the last completed operation |
| flag_z | output | 1 | Quotient is zero |
| flag_v | output | 1 | Fractional quotient would exceed 16 bits |
| flag_c | output | 1 | Divisor was zero |

## Verification
Two functions can fall in the same cycle: the completion of one operation and the arrival of the next request. The first case is a new `start` driven in the very cycle `done` is high, which must be accepted and yield its own correct result and latency. The second is a `start` with different operands driven while iterations run, which must leave the running quotient, remainder and 16-cycle latency untouched. Each is judged against results the bench computes with plain 32-bit arithmetic and against the counted number of edges to `done`.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

    typedef enum logic {
        MODE_INT  = 1'b0,
        MODE_FRAC = 1'b1
    } div_mode_e;

endpackage

// File: rtl/udiv_screen.sv
// Classifies a request before iterating: zero divisor or fractional overflow.
module udiv_screen #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]  dividend,
    input  logic [WIDTH-1:0]  divisor,
    input  udiv_pkg::div_mode_e mode,
    output logic              zero_div,
    output logic              frac_ovf,
    output logic              early
);
    always_comb begin
        zero_div = (divisor == '0);
        frac_ovf = (mode == udiv_pkg::MODE_FRAC) && (divisor <= dividend);
        early    = zero_div || frac_ovf;
    end
endmodule

// File: rtl/udiv_step.sv
// One restoring iteration: shift one bit in, trial-subtract, keep or restore.
module udiv_step #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] part_in,
    input  logic [WIDTH-1:0] shreg_in,
    input  logic [WIDTH-1:0] dsr,
    output logic [WIDTH-1:0] part_out,
    output logic [WIDTH-1:0] shreg_out
);
    logic [WIDTH:0]   shifted;
    logic             fits;
    logic [WIDTH-1:0] trial;

    always_comb begin
        shifted   = {part_in, shreg_in[WIDTH-1]};
        fits      = (shifted >= {1'b0, dsr});
        trial     = shifted[WIDTH-1:0] - dsr;
        part_out  = fits ? trial : shifted[WIDTH-1:0];
        shreg_out = {shreg_in[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/udiv_unit.sv
module udiv_unit #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             frac_mode,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c
);
    import udiv_pkg::*;

    localparam int            CNT_W    = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_IT = CNT_W'(WIDTH - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] part;
        logic [WIDTH-1:0] shreg;
        logic [WIDTH-1:0] dsr;
        div_mode_e        mode;
        logic             done;
        logic [WIDTH-1:0] quot;
        logic [WIDTH-1:0] rem;
        logic             z;
        logic             v;
        logic             c;
    } div_state_t;

    div_state_t state_d, state_q;

    div_mode_e        req_mode;
    logic             zero_div, frac_ovf, early;
    logic [WIDTH-1:0] part_nx, shreg_nx;

    assign req_mode = div_mode_e'(frac_mode);

    udiv_screen #(.WIDTH(WIDTH)) u_screen (
        .dividend (dividend),
        .divisor  (divisor),
        .mode     (req_mode),
        .zero_div (zero_div),
        .frac_ovf (frac_ovf),
        .early    (early)
    );

    udiv_step #(.WIDTH(WIDTH)) u_step (
        .part_in   (state_q.part),
        .shreg_in  (state_q.shreg),
        .dsr       (state_q.dsr),
        .part_out  (part_nx),
        .shreg_out (shreg_nx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (!state_q.busy) begin
            if (start) begin
                state_d.dsr  = divisor;
                state_d.mode = req_mode;
                if (early) begin
                    state_d.done = 1'b1;
                    state_d.quot = '1;
                    state_d.rem  = dividend;
                    state_d.z    = 1'b0;
                    state_d.v    = frac_ovf;
                    state_d.c    = zero_div;
                end else begin
                    state_d.busy  = 1'b1;
                    state_d.cnt   = '0;
                    state_d.part  = (req_mode == MODE_FRAC) ? dividend : '0;
                    state_d.shreg = (req_mode == MODE_FRAC) ? '0 : dividend;
                end
            end
        end else begin
            state_d.part  = part_nx;
            state_d.shreg = shreg_nx;
            state_d.cnt   = state_q.cnt + 1'b1;
            if (state_q.cnt == LAST_IT) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
                state_d.quot = shreg_nx;
                state_d.rem  = part_nx;
                state_d.z    = (shreg_nx == '0);
                state_d.v    = 1'b0;
                state_d.c    = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign busy      = state_q.busy;
    assign done      = state_q.done;
    assign quotient  = state_q.quot;
    assign remainder = state_q.rem;
    assign flag_z    = state_q.z;
    assign flag_v    = state_q.v;
    assign flag_c    = state_q.c;

    a_r1_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !flag_c && !flag_v) |-> (remainder < state_q.dsr));

    a_r3_carry_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_c == (state_q.dsr == '0)));

    a_r4_int_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state_q.mode == MODE_INT) |-> !flag_v);

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (flag_z == (quotient == '0)));

    a_r7_busy_ends_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r9_divisor_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(state_q.dsr));

endmodule

// File: tb/udiv_unit_bench.sv
module udiv_unit_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        frac_mode = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        busy, done, flag_z, flag_v, flag_c;
    logic [15:0] quotient, remainder;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    udiv_unit u_udiv_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .frac_mode(frac_mode),
        .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected results from plain arithmetic.
    task automatic expect_of(input logic [15:0] d, input logic [15:0] x, input logic m,
                             output logic [15:0] eq, output logic [15:0] er,
                             output logic ez, output logic ev, output logic ec,
                             output int elat);
        logic [31:0] num;
        ec = (x == 0);
        ev = m && (x <= d);
        if (ec || ev) begin
            eq = 16'hFFFF; er = d; elat = 1;
        end else begin
            num = m ? {d, 16'h0} : {16'h0, d};
            eq = 16'(num / {16'h0, x});
            er = 16'(num % {16'h0, x});
            elat = 17;
        end
        ez = (eq == 0);
    endtask

    task automatic check_result(input logic [15:0] d, input logic [15:0] x, input logic m,
                                input int lat, input int busy_bad);
        logic [15:0] eq, er;
        logic ez, ev, ec;
        int elat;
        expect_of(d, x, m, eq, er, ez, ev, ec, elat);
        chk(m ? "R2 quotient" : "R1 quotient", quotient, eq);
        chk(m ? "R2 remainder" : "R1 remainder", remainder, er);
        chk("R3 flag_c", flag_c, ec);
        chk("R4 flag_v", flag_v, ev);
        chk("R5 flag_z", flag_z, ez);
        chk(elat == 1 ? "R6 latency" : "R7 latency", lat, elat);
        if (elat != 1) chk("R7 busy during iterations", busy_bad, 0);
    endtask

    // Waits for done after the accepting edge; returns edge count and busy misses.
    task automatic wait_done(output int lat, output int busy_bad);
        lat = 1; busy_bad = 0;
        while (!done && lat < 40) begin
            if (!busy) busy_bad++;
            @(posedge clk); #1;
            lat++;
        end
        if (busy) busy_bad++;
    endtask

    task automatic run_op(input logic [15:0] d, input logic [15:0] x, input logic m);
        int lat, bb;
        logic [15:0] q0;
        @(negedge clk);
        start = 1'b1; dividend = d; divisor = x; frac_mode = m;
        @(posedge clk); #1;
        start = 1'b0; dividend = ~d; divisor = ~x;
        wait_done(lat, bb);
        check_result(d, x, m, lat, bb);
        q0 = quotient;
        @(posedge clk); #1;
        chk("R8 done single cycle", done, 0);
        chk("R8 quotient held", quotient, q0);
    endtask

    task automatic t_reset;
        chk("R8 reset done", done, 0);
        chk("R8 reset busy", busy, 0);
        chk("R8 reset quotient", quotient, 0);
        chk("R8 reset remainder", remainder, 0);
        chk("R8 reset flags", {flag_z, flag_v, flag_c}, 0);
    endtask

    task automatic t_integer;
        run_op(16'd1000, 16'd7, 1'b0);
        run_op(16'd15, 16'd15, 1'b0);
        run_op(16'd0, 16'd9, 1'b0);
        run_op(16'hFFFF, 16'd1, 1'b0);
        run_op(16'hFFFF, 16'hFFFF, 1'b0);
        run_op(16'd5, 16'd200, 1'b0);
        run_op(16'hFFFF, 16'd15, 1'b0);
    endtask

    task automatic t_fraction;
        run_op(16'd1, 16'd3, 1'b1);
        run_op(16'd0, 16'd1, 1'b1);
        run_op(16'd1000, 16'd5311, 1'b1);
        run_op(16'hFFFE, 16'hFFFF, 1'b1);
    endtask

    task automatic t_zero_divisor;
        run_op(16'd1234, 16'd0, 1'b0);
        run_op(16'd0, 16'd0, 1'b0);
        run_op(16'd77, 16'd0, 1'b1);
    endtask

    task automatic t_frac_overflow;
        run_op(16'd9, 16'd9, 1'b1);
        run_op(16'hFFFF, 16'd1, 1'b1);
        run_op(16'd100, 16'd3, 1'b1);
    endtask

    task automatic t_ignore_busy;
        int lat, bb;
        @(negedge clk);
        start = 1'b1; dividend = 16'd1000; divisor = 16'd7; frac_mode = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        start = 1'b1; dividend = 16'd3; divisor = 16'd0; frac_mode = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        lat = 5; bb = 0;
        while (!done && lat < 40) begin
            @(posedge clk); #1;
            lat++;
        end
        // R9: the result and latency belong to the first request only
        check_result(16'd1000, 16'd7, 1'b0, lat, bb);
    endtask

    task automatic t_back_to_back;
        int lat, bb;
        @(negedge clk);
        start = 1'b1; dividend = 16'd500; divisor = 16'd6; frac_mode = 1'b0;
        @(posedge clk); #1;
        start = 1'b0;
        wait_done(lat, bb);
        check_result(16'd500, 16'd6, 1'b0, lat, bb);
        // R10: request driven in the done cycle
        start = 1'b1; dividend = 16'd2; divisor = 16'd7; frac_mode = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk("R10 accepted in done cycle", busy, 1);
        wait_done(lat, bb);
        check_result(16'd2, 16'd7, 1'b1, lat, bb);
    endtask

    task automatic t_random;
        logic [31:0] s = 32'h1D2C3B4A;
        for (int i = 0; i < 24; i++) begin
            logic [15:0] d, x;
            logic m;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            d = s[15:0]; x = s[31:16];
            m = i[0];
            if (m && x <= d && i[1]) x = d + 16'd1 + {8'h0, s[7:0]};
            if (i % 6 == 5) x = {12'h0, s[19:16]};
            run_op(d, x, m);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_integer();
        t_fraction();
        t_zero_divisor();
        t_frac_overflow();
        t_ignore_busy();
        t_back_to_back();
        t_random();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule